// File: doc/BRIEF.md
# Buffered Dual Capture/Compare Channel

This block holds two identical timer sub-channels. Each one has a main register and a sub register, and the pair works either as a capture unit or as a compare unit. The block reads the count values of two free-running timers, and it does not build those timers itself.

In capture mode, an external event latches timer values into the registers. Reading the main register releases a hold on further events, or it moves the buffered sample into the main register. In compare mode, software writes the sub register. The sub register either mirrors into the main register on the next cycle or waits as a shadow copy until a transfer. A transfer is started by an external trigger or by a compare match.

A single 16-bit control register sets the mode of both sub-channels. The CPU reads and writes the block through a small address space. Each sub-channel drives a one-cycle compare-match pulse.

Top module: `buf_cc_pair`

## Requirements
- R1: The control register is 16 bits wide and resets to 0x0000. Sub-channel 1 uses bits 5:0 and sub-channel 2 uses bits 13:8. Within a field, bit 5 is event enable, bit 4 is buffer enable, bit 3 is link enable, bit 2 is mode (1 = compare, 0 = capture) and bits 1:0 are the timer select (0 = first timer, any other code = second timer). Bits 15:14 and 7:6 always read as zero. The address map is: 0 = control, 1 = sub-channel 1 sub, 2 = sub-channel 1 main, 3 = sub-channel 2 sub, 4 = sub-channel 2 main. Writes take effect at the clock edge, and reads return data combinationally.
- R2: While event enable is 0, an event input changes neither register of its sub-channel.
- R3: In unbuffered capture mode, an enabled event latches the first timer into the sub register and the second timer into the main register at the same clock edge.
- R4: In unbuffered capture mode, once a capture has happened, later events are ignored until the CPU reads the main register.
- R5: In buffered capture mode, each event stores the selected timer into the sub register only. A CPU read of the main register returns the current main value, and the main register then loads the value the sub register held before that read.
- R6: If a CPU read of the main register coincides with an event, the read returns the old main value and the capture happens one cycle later.
- R7: In unbuffered compare mode, a CPU write to the sub register appears in the main register one clock after it appears in the sub register.
- R8: In compare mode, the match output rises for the cycle after a clock edge at which the selected timer equals the main register. It never rises in capture mode.
- R9: In buffered compare mode with link enable 1, a CPU write reaches only the sub register. The sub register is copied into the main register when the transfer trigger input is high.
- R10: In buffered compare mode with link enable 0, the transfer trigger input is ignored and the copy happens on each compare match.
- R11: The first compare match after reset, or after entering buffered compare mode, copies sub to main whatever the link enable setting is.
- R12: Sub-channel 2 uses event input bit 1, addresses 3 and 4, and match output bit 1, independently of sub-channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_a_i | input | TW | First timer count |
| tmr_b_i | input | TW | Second timer count |
| evt_i | input | 2 | Event strobes, one per sub-channel |
| xfer_i | input | 1 | Transfer trigger for buffered compare |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_addr_i | input | 3 | CPU register address |
| cpu_wdata_i | input | TW | CPU write data |
| cpu_rdata_o | output | TW | CPU read data |
| match_o | output | 2 | Compare-match pulses, one per sub-channel |

## Verification
Unbuffered capture is driven from a table of timer pairs that includes all-ones, all-zeros, swapped extremes and small values. A swap of the timer-to-register roles, or a lost bit, shows up as a mismatch.

Directed sequences cover the following cases:
- Events while locked and while disabled, which separate the interlock from the event gate.
- A read that coincides with an event, which tells a deferred capture apart from a dropped one.
- Compare writes sampled one cycle apart, which expose whether the mirror copy arrives early, late or not at all.
- Trigger pulses with link on and off, and a match right after reset, which separate the three ways a buffered transfer can start.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int NSLOT      = 2;
  localparam int FIELD_W    = 6;
  localparam int FLD_STRIDE = 8;
  localparam int CTRL_W     = 16;
  localparam int AW         = 3;
  localparam logic [AW-1:0] ADDR_CTRL = '0;

  typedef struct packed {
    logic       evt_en;
    logic       buf_en;
    logic       link_en;
    logic       cmp_sel;
    logic [1:0] tsel;
  } slot_cfg_t;
endpackage

// File: rtl/cc_rst_sync.sv
module cc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/cc_ctrl_reg.sv
module cc_ctrl_reg
  import cc_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [CTRL_W-1:0]            wdata,
  output slot_cfg_t [NSLOT-1:0]        cfg_o,
  output logic [CTRL_W-1:0]            word_o
);
  slot_cfg_t [NSLOT-1:0] cfg_q, cfg_n;

  always_comb begin
    cfg_n = cfg_q;
    if (wr_en) begin
      for (int k = 0; k < NSLOT; k++) begin
        cfg_n[k] = slot_cfg_t'(wdata[k*FLD_STRIDE +: FIELD_W]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_n;
  end

  always_comb begin
    word_o = '0;
    for (int k = 0; k < NSLOT; k++) begin
      word_o[k*FLD_STRIDE +: FIELD_W] = cfg_q[k];
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/cc_slot.sv
module cc_slot
  import cc_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  slot_cfg_t     cfg,
  input  logic [TW-1:0] tmr_a,
  input  logic [TW-1:0] tmr_b,
  input  logic          evt,
  input  logic          xfer,
  input  logic          wr_sub,
  input  logic [TW-1:0] wdata,
  input  logic          rd_main,
  output logic [TW-1:0] sub_o,
  output logic [TW-1:0] main_o,
  output logic          match_o,
  output logic          lock_o,
  output logic          defer_o
);
  logic [TW-1:0] sub_q, sub_n, main_q, main_n;
  logic          lock_q, lock_n, defer_q, defer_n;
  logic          pend_q, pend_n, prime_q, prime_n, match_q;
  logic [TW-1:0] sel_t;
  logic          eq, cap_req, xfer_go;

  assign sel_t   = (cfg.tsel == 2'd0) ? tmr_a : tmr_b;
  assign eq      = cfg.cmp_sel && (sel_t == main_q);
  assign cap_req = !cfg.cmp_sel && ((cfg.evt_en && evt) || defer_q);
  assign xfer_go = cfg.cmp_sel && cfg.buf_en &&
                   ((cfg.link_en ? xfer : eq) || (prime_q && eq));

  always_comb begin
    sub_n   = sub_q;
    main_n  = main_q;
    lock_n  = lock_q;
    defer_n = 1'b0;
    pend_n  = 1'b0;
    prime_n = prime_q;
    if (!cfg.cmp_sel) begin
      prime_n = 1'b1;
      if (rd_main) begin
        lock_n  = 1'b0;
        defer_n = cap_req;
        if (cfg.buf_en) main_n = sub_q;
      end else if (cap_req) begin
        if (cfg.buf_en) begin
          sub_n = sel_t;
        end else if (!lock_q) begin
          sub_n  = tmr_a;
          main_n = tmr_b;
          lock_n = 1'b1;
        end
      end
    end else begin
      lock_n = 1'b0;
      if (!cfg.buf_en) begin
        prime_n = 1'b1;
        if (pend_q) main_n = sub_q;
        if (wr_sub) begin
          sub_n  = wdata;
          pend_n = 1'b1;
        end
      end else begin
        if (wr_sub) sub_n = wdata;
        if (xfer_go) begin
          main_n  = sub_q;
          prime_n = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q   <= '0;
      main_q  <= '0;
      lock_q  <= 1'b0;
      defer_q <= 1'b0;
      pend_q  <= 1'b0;
      prime_q <= 1'b1;
      match_q <= 1'b0;
    end else begin
      sub_q   <= sub_n;
      main_q  <= main_n;
      lock_q  <= lock_n;
      defer_q <= defer_n;
      pend_q  <= pend_n;
      prime_q <= prime_n;
      match_q <= eq;
    end
  end

  assign sub_o   = sub_q;
  assign main_o  = main_q;
  assign match_o = match_q;
  assign lock_o  = lock_q;
  assign defer_o = defer_q;
endmodule

// File: rtl/buf_cc_pair.sv
module buf_cc_pair
  import cc_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tmr_a_i,
  input  logic [TW-1:0] tmr_b_i,
  input  logic [1:0]    evt_i,
  input  logic          xfer_i,
  input  logic          cpu_wr_i,
  input  logic          cpu_rd_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [TW-1:0] cpu_wdata_i,
  output logic [TW-1:0] cpu_rdata_o,
  output logic [1:0]    match_o
);
  logic                          srst_n;
  slot_cfg_t [NSLOT-1:0]         cfg_v;
  logic [CTRL_W-1:0]             ctrl_word;
  logic [NSLOT-1:0][TW-1:0]      sub_v, main_v;
  logic [NSLOT-1:0]              wr_sub, rd_main, lock_v, defer_v;

  cc_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  cc_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (srst_n),
    .wr_en  (cpu_wr_i && (cpu_addr_i == ADDR_CTRL)),
    .wdata  (cpu_wdata_i[CTRL_W-1:0]),
    .cfg_o  (cfg_v),
    .word_o (ctrl_word)
  );

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    localparam logic [AW-1:0] SUB_A  = AW'(2*k+1);
    localparam logic [AW-1:0] MAIN_A = AW'(2*k+2);

    assign wr_sub[k]  = cpu_wr_i && (cpu_addr_i == SUB_A);
    assign rd_main[k] = cpu_rd_i && (cpu_addr_i == MAIN_A);

    cc_slot #(.TW(TW)) u_slot (
      .clk     (clk),
      .rst_n   (srst_n),
      .cfg     (cfg_v[k]),
      .tmr_a   (tmr_a_i),
      .tmr_b   (tmr_b_i),
      .evt     (evt_i[k]),
      .xfer    (xfer_i),
      .wr_sub  (wr_sub[k]),
      .wdata   (cpu_wdata_i),
      .rd_main (rd_main[k]),
      .sub_o   (sub_v[k]),
      .main_o  (main_v[k]),
      .match_o (match_o[k]),
      .lock_o  (lock_v[k]),
      .defer_o (defer_v[k])
    );
  end

  always_comb begin
    cpu_rdata_o = '0;
    if (cpu_addr_i == ADDR_CTRL) cpu_rdata_o = TW'(ctrl_word);
    for (int k = 0; k < NSLOT; k++) begin
      if (cpu_addr_i == AW'(2*k+1)) cpu_rdata_o = sub_v[k];
      if (cpu_addr_i == AW'(2*k+2)) cpu_rdata_o = main_v[k];
    end
  end
endmodule

// File: rtl/cc_pair_chk.sv
module cc_pair_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_rd,
  input logic          cpu_wr,
  input logic [2:0]    cpu_addr,
  input logic [TW-1:0] cpu_rdata,
  input logic [15:0]   ctl,
  input logic [TW-1:0] sub0,
  input logic [TW-1:0] main0,
  input logic          lock0,
  input logic          defer0,
  input logic [1:0]    match
);
  // R1: reserved control bits read back as zero
  assert_ctrl_resv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr == 3'd0) |-> (cpu_rdata[15:14] == 2'b00 && cpu_rdata[7:6] == 2'b00));

  // R2: with events disabled in capture mode the sub register holds
  assert_evt_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl[5] && !ctl[2] && !defer0) |=> $stable(sub0));

  // R4: a locked unbuffered capture holds main until it is read
  assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock0 && !ctl[2] && !ctl[4] && !(cpu_rd && cpu_addr == 3'd2)) |=> $stable(main0));

  // R5: a buffered capture read moves the prior sub value into main
  assert_buf_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl[2] && ctl[4] && cpu_rd && cpu_addr == 3'd2) |=> (main0 == $past(sub0)));

  // R7: an unbuffered compare write reaches main one cycle after sub
  assert_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cpu_wr && cpu_addr == 3'd1) && ctl[2] && !ctl[4] && !cpu_wr) |=> (main0 == $past(sub0)));

  // R8: no match pulse unless compare mode was selected
  assert_match_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match[0] |-> $past(ctl[2]));
endmodule

bind buf_cc_pair cc_pair_chk #(.TW(TW)) i_chk (
  .clk       (clk),
  .rst_n     (srst_n),
  .cpu_rd    (cpu_rd_i),
  .cpu_wr    (cpu_wr_i),
  .cpu_addr  (cpu_addr_i),
  .cpu_rdata (cpu_rdata_o),
  .ctl       (ctrl_word),
  .sub0      (sub_v[0]),
  .main0     (main_v[0]),
  .lock0     (lock_v[0]),
  .defer0    (defer_v[0]),
  .match     (match_o)
);

// File: tb/test_buf_cc_pair.sv
module test_buf_cc_pair;
  localparam int TW = 16;
  localparam logic [31:0] CAP_VEC [0:5] = '{
    32'h1234_ABCD, 32'h0000_FFFF, 32'hFFFF_0000,
    32'h8001_7FFE, 32'h5A5A_A5A5, 32'h0001_0002
  };

  logic          clk, rst_n, xfer, cpu_wr, cpu_rd;
  logic [TW-1:0] tmr_a, tmr_b, cpu_wdata, cpu_rdata;
  logic [1:0]    evt, match;
  logic [2:0]    cpu_addr;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done  = 0;

  buf_cc_pair #(.TW(TW)) i_buf_cc_pair (
    .clk(clk), .rst_n(rst_n), .tmr_a_i(tmr_a), .tmr_b_i(tmr_b),
    .evt_i(evt), .xfer_i(xfer), .cpu_wr_i(cpu_wr), .cpu_rd_i(cpu_rd),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_rdata_o(cpu_rdata), .match_o(match)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [TW-1:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    tick();
    cpu_wr = 1'b0;
  endtask

  task automatic rdchk(input logic [2:0] a, input logic [TW-1:0] exp, input string tag);
    cpu_rd = 1'b1; cpu_addr = a;
    #1 chk(tag, 32'(cpu_rdata), 32'(exp));
    tick();
    cpu_rd = 1'b0;
  endtask

  task automatic pulse_evt(input logic [1:0] m, input logic [TW-1:0] a, input logic [TW-1:0] b);
    tmr_a = a; tmr_b = b; evt = m;
    tick();
    evt = 2'b00;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tmr_a = '0; tmr_b = '0; evt = '0; xfer = 1'b0;
    cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    do_reset();

    // R1 reset state
    rdchk(3'd0, 16'h0000, "R1 ctrl reset");
    rdchk(3'd1, 16'h0000, "R1 sub1 reset");
    rdchk(3'd2, 16'h0000, "R1 main1 reset");
    rdchk(3'd4, 16'h0000, "R1 main2 reset");
    chk("R1 match reset", 32'(match), 32'h0);
    // R1 reserved bits
    wr(3'd0, 16'hFFFF);
    rdchk(3'd0, 16'h3F3F, "R1 reserved zero");
    wr(3'd0, 16'h0000);

    // R2 events disabled
    pulse_evt(2'b11, 16'h1111, 16'h2222);
    rdchk(3'd1, 16'h0000, "R2 sub1 ignored");
    rdchk(3'd2, 16'h0000, "R2 main1 ignored");
    rdchk(3'd3, 16'h0000, "R2 sub2 ignored");

    // R3 unbuffered capture, table driven
    wr(3'd0, 16'h0020);
    for (int i = 0; i < 6; i++) begin
      pulse_evt(2'b01, CAP_VEC[i][31:16], CAP_VEC[i][15:0]);
      rdchk(3'd1, CAP_VEC[i][31:16], "R3 sub takes first timer");
      rdchk(3'd2, CAP_VEC[i][15:0], "R3 main takes second timer");
    end

    // R4 interlock
    pulse_evt(2'b01, 16'h0101, 16'h0202);
    pulse_evt(2'b01, 16'h0303, 16'h0404);
    rdchk(3'd1, 16'h0101, "R4 sub held while locked");
    rdchk(3'd2, 16'h0202, "R4 main held while locked");
    pulse_evt(2'b01, 16'h0303, 16'h0404);
    rdchk(3'd1, 16'h0303, "R4 capture after unlock");
    rdchk(3'd2, 16'h0404, "R4 main after unlock");

    // R5 buffered capture, second timer selected
    wr(3'd0, 16'h0031);
    pulse_evt(2'b01, 16'h0000, 16'h0AAA);
    rdchk(3'd1, 16'h0AAA, "R5 sub captures");
    rdchk(3'd2, 16'h0404, "R5 main old on read");
    rdchk(3'd2, 16'h0AAA, "R5 main loaded from sub");

    // R6 read coinciding with event
    pulse_evt(2'b01, 16'h0000, 16'h0BBB);
    tmr_b = 16'h0CCC; evt = 2'b01; cpu_rd = 1'b1; cpu_addr = 3'd2;
    #1 chk("R6 coincident read old main", 32'(cpu_rdata), 32'h0AAA);
    tick();
    evt = 2'b00; cpu_rd = 1'b0;
    rdchk(3'd1, 16'h0BBB, "R6 capture deferred");
    rdchk(3'd1, 16'h0CCC, "R6 deferred capture done");
    rdchk(3'd2, 16'h0BBB, "R6 main from prior sub");

    // R7 unbuffered compare mirror
    tmr_a = 16'h7000; tmr_b = 16'h6000;
    wr(3'd0, 16'h0004);
    wr(3'd1, 16'h0055);
    rdchk(3'd2, 16'h0CCC, "R7 main not yet copied");
    rdchk(3'd2, 16'h0055, "R7 main copied");

    // R8 match pulse
    tmr_a = 16'h0055; tick();
    chk("R8 match on first timer", 32'(match), 32'h1);
    tmr_a = 16'h7000; tick();
    chk("R8 match drops", 32'(match), 32'h0);
    wr(3'd0, 16'h0005);
    tmr_a = 16'h0055; tick();
    chk("R8 select ignores first timer", 32'(match), 32'h0);
    tmr_a = 16'h7000; tmr_b = 16'h0055; tick();
    chk("R8 match on second timer", 32'(match), 32'h1);
    tmr_b = 16'h6000;
    wr(3'd0, 16'h0001);
    tmr_b = 16'h0055; tick();
    chk("R8 no match in capture", 32'(match), 32'h0);
    tmr_b = 16'h6000;

    // R9 buffered compare with link
    wr(3'd0, 16'h001C);
    wr(3'd1, 16'h0077);
    rdchk(3'd2, 16'h0055, "R9 write held in sub");
    tick();
    rdchk(3'd2, 16'h0055, "R9 no transfer without trigger");
    xfer = 1'b1; tick(); xfer = 1'b0;
    rdchk(3'd2, 16'h0077, "R9 transfer on trigger");

    // R10 buffered compare without link
    wr(3'd0, 16'h0014);
    wr(3'd1, 16'h0099);
    xfer = 1'b1; tick(); xfer = 1'b0;
    rdchk(3'd2, 16'h0077, "R10 trigger ignored");
    tmr_a = 16'h0077; tick();
    chk("R10 match pulse", 32'(match), 32'h1);
    tmr_a = 16'h7000;
    rdchk(3'd2, 16'h0099, "R10 transfer on match");

    // R11 first match after reset transfers
    tmr_a = 16'h0010;
    do_reset();
    wr(3'd0, 16'h001C);
    wr(3'd1, 16'h0033);
    rdchk(3'd2, 16'h0000, "R11 main zero before start");
    tmr_a = 16'h0000; tick();
    chk("R11 start match", 32'(match), 32'h1);
    tmr_a = 16'h0010;
    rdchk(3'd2, 16'h0033, "R11 first match transfers");
    wr(3'd1, 16'h0044);
    tmr_a = 16'h0033; tick();
    chk("R11 later match", 32'(match), 32'h1);
    tmr_a = 16'h0010;
    rdchk(3'd2, 16'h0033, "R11 later match gated by link");

    // R12 second sub-channel
    tmr_a = 16'h0500;
    wr(3'd0, 16'h0400);
    wr(3'd3, 16'h0021);
    tick();
    rdchk(3'd4, 16'h0021, "R12 ch2 mirror");
    tmr_a = 16'h0021; tick();
    chk("R12 ch2 match bit", 32'(match), 32'h2);
    tmr_a = 16'h0500;
    wr(3'd0, 16'h2000);
    pulse_evt(2'b10, 16'h0A0A, 16'h0B0B);
    rdchk(3'd3, 16'h0A0A, "R12 ch2 sub capture");
    rdchk(3'd4, 16'h0B0B, "R12 ch2 main capture");
    pulse_evt(2'b01, 16'h0C0C, 16'h0D0D);
    rdchk(3'd3, 16'h0A0A, "R12 ch1 event leaves ch2");

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule